// File: doc/BRIEF.md
# Resource-Limited Thread Block Dispatcher

This block hands out the thread blocks of one kernel launch to a row of processor slots. A launch is described by four numbers: how many blocks there are, how many threads each block has, how many bytes of on-chip shared storage each block claims, and how many registers each of its threads claims. Every slot keeps three running totals, for threads, shared bytes and registers. A block may land on a slot only when all three totals, after the block is added, stay within that slot's limits. Whichever pool runs short first therefore sets how many blocks a slot can hold at once.

Blocks go out strictly in ascending ID order, at most one per cycle, and each goes to the lowest-numbered slot with room. Blocks that find no room wait and go out as resident blocks finish, so a large launch drains in waves. A completion strobe for a slot gives one block's allocation back to that slot in the same cycle. A dispatch decided in that cycle can use the freed room. Once every block has been dispatched and has completed, a done flag rises. It stays high until the next launch is accepted.

Top module: `block_dispatcher`

## Requirements
- R1: A launch is refused when it has zero blocks, zero threads, more than 1024 threads per block, more than 196608 shared bytes per block, or more than 65536 registers per block (threads times registers per thread). A refusal is shown as `launch_reject` high for the cycle after the request, and no block is dispatched.
- R2: A block is placed on a slot only if, after it is added, the slot holds at most 2048 threads, 196608 shared bytes and 65536 registers.
- R3: The number of blocks resident on a full slot equals the smallest of the three per-resource limits. Examples: 256-thread blocks without shared storage give 8. 256-thread blocks with 65536 shared bytes give 3. 256 threads at 255 registers give 1.
- R4: Blocks are dispatched with IDs 0, 1, 2, ... in order, at most one per cycle. Each dispatch shows as `disp_valid` high for one cycle, with its ID and slot.
- R5: Each block goes to the lowest-numbered slot that has room for it.
- R6: A completion frees its block's resources in the cycle it is asserted. A waiting block can be placed on that slot in that same cycle, and the dispatch appears on the outputs in the following cycle.
- R7: Blocks that do not fit wait. Every block of the launch is eventually dispatched, exactly once, as completions arrive.
- R8: `done` rises in the cycle after the last block's completion, once all blocks have been dispatched. It holds until the next accepted launch, and it is low while a launch is in progress.
- R9: A completion strobe for a slot with no resident blocks has no effect. It changes neither the occupancy nor the completion count.
- R10: A launch request made while a launch is in progress is ignored. It is neither refused nor accepted.
- R11: After reset, no dispatch, refusal or done is signalled, and every slot's occupancy is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Launch request, sampled while idle |
| launch_blocks | input | BLK_W | Number of blocks in the launch |
| launch_threads | input | THR_W (12) | Threads per block |
| launch_smem | input | SMEM_W (18) | Shared bytes per block |
| launch_regs | input | RPT_W (8) | Registers per thread |
| launch_reject | output | 1 | Refused launch, one cycle |
| blk_complete | input | NUM_SM | One completion strobe per slot |
| disp_valid | output | 1 | A block was dispatched |
| disp_block | output | BLK_W | ID of the dispatched block |
| disp_sm | output | SM_W | Slot that received the block |
| sm_occupancy | output | NUM_SM*OCC_W | Resident block count per slot, slot 0 in the low bits |
| done | output | 1 | Whole launch dispatched and completed |

## Verification
Each of the three pools is driven separately into being the binding limit. Exact-fit launches, such as a block claiming all 196608 shared bytes or exactly 65536 registers, catch a comparison that is off by one. Such a design would either refuse to place a legal block or let a slot overfill. A completion followed at once by a waiting block catches a release that lands one cycle late; the dispatch would then appear a cycle after it should. Completion strobes aimed at empty slots, and a second launch sent mid-run, expose a design that counts phantom completions and raises done early, or one that disturbs a running launch.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int unsigned SM_THREAD_CAP  = 2048;
  localparam int unsigned SM_SMEM_CAP    = 196608;
  localparam int unsigned SM_REG_CAP     = 65536;
  localparam int unsigned BLK_THREAD_MAX = 1024;
  localparam int unsigned RPT_MAX        = 255;

  localparam int THR_W  = $clog2(SM_THREAD_CAP + 1);
  localparam int SMEM_W = $clog2(SM_SMEM_CAP + 1);
  localparam int REG_W  = $clog2(SM_REG_CAP + 1);
  localparam int RPT_W  = $clog2(RPT_MAX + 1);
  localparam int MUL_W  = THR_W + RPT_W;
  localparam int OCC_W  = THR_W;

  // Resource claim of one block of the running launch
  typedef struct packed {
    logic [THR_W-1:0]  thr;
    logic [SMEM_W-1:0] smem;
    logic [REG_W-1:0]  regs;
  } blk_cost_t;
endpackage

// File: rtl/bd_sm_pool.sv
module bd_sm_pool
  import bd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  blk_cost_t         cost,
  input  logic              alloc,
  input  logic              rel_req,
  output logic              fits,
  output logic              rel_ok,
  output logic [OCC_W-1:0]  occ,
  output logic [THR_W-1:0]  thr_used,
  output logic [SMEM_W-1:0] smem_used,
  output logic [REG_W-1:0]  reg_used
);
  logic [THR_W-1:0]  thr_q, thr_d, thr_base;
  logic [SMEM_W-1:0] smem_q, smem_d, smem_base;
  logic [REG_W-1:0]  reg_q, reg_d, reg_base;
  logic [OCC_W-1:0]  occ_q, occ_d;
  logic [THR_W:0]    thr_sum;
  logic [SMEM_W:0]   smem_sum;
  logic [REG_W:0]    reg_sum;
  logic              pool_en;

  // a strobe on an empty slot is dropped
  assign rel_ok = rel_req && (occ_q != '0);

  // usage after this cycle's release
  always_comb begin
    thr_base  = rel_ok ? (thr_q  - cost.thr)  : thr_q;
    smem_base = rel_ok ? (smem_q - cost.smem) : smem_q;
    reg_base  = rel_ok ? (reg_q  - cost.regs) : reg_q;
    thr_sum   = {1'b0, thr_base}  + {1'b0, cost.thr};
    smem_sum  = {1'b0, smem_base} + {1'b0, cost.smem};
    reg_sum   = {1'b0, reg_base}  + {1'b0, cost.regs};
  end

  assign fits = (thr_sum  <= (THR_W+1)'(SM_THREAD_CAP)) &&
                (smem_sum <= (SMEM_W+1)'(SM_SMEM_CAP)) &&
                (reg_sum  <= (REG_W+1)'(SM_REG_CAP));

  always_comb begin
    thr_d  = alloc ? thr_sum[THR_W-1:0]   : thr_base;
    smem_d = alloc ? smem_sum[SMEM_W-1:0] : smem_base;
    reg_d  = alloc ? reg_sum[REG_W-1:0]   : reg_base;
    occ_d  = occ_q;
    if (rel_ok) occ_d = occ_d - 1'b1;
    if (alloc)  occ_d = occ_d + 1'b1;
  end

  assign pool_en = alloc | rel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= '0;
      smem_q <= '0;
      reg_q  <= '0;
      occ_q  <= '0;
    end else if (pool_en) begin
      thr_q  <= thr_d;
      smem_q <= smem_d;
      reg_q  <= reg_d;
      occ_q  <= occ_d;
    end
  end

  assign occ       = occ_q;
  assign thr_used  = thr_q;
  assign smem_used = smem_q;
  assign reg_used  = reg_q;
endmodule

// File: rtl/bd_pick.sv
module bd_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // lowest index wins: scan downward, last hit stays
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  assign any = |req;
endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
  import bd_pkg::*;
#(
  parameter int NUM_SM = 4,
  parameter int BLK_W  = 16,
  localparam int SM_W  = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch_valid,
  input  logic [BLK_W-1:0]        launch_blocks,
  input  logic [THR_W-1:0]        launch_threads,
  input  logic [SMEM_W-1:0]       launch_smem,
  input  logic [RPT_W-1:0]        launch_regs,
  output logic                    launch_reject,
  input  logic [NUM_SM-1:0]       blk_complete,
  output logic                    disp_valid,
  output logic [BLK_W-1:0]        disp_block,
  output logic [SM_W-1:0]         disp_sm,
  output logic [NUM_SM*OCC_W-1:0] sm_occupancy,
  output logic                    done
);
  blk_cost_t            cost_q, cost_d, cost_in;
  logic [BLK_W-1:0]     total_q, total_d, next_q, next_d, fin_q, fin_d, fin_sum;
  logic                 busy_q, busy_d, done_q, done_d, rej_q, rej_d;
  logic                 dv_q, dv_d;
  logic [BLK_W-1:0]     db_q;
  logic [SM_W-1:0]      ds_q, pick_idx;
  logic [MUL_W-1:0]     req_regs;
  logic                 bad, accept, pending, any_fit, disp_go, st_en;
  logic [NUM_SM-1:0]    fits_vec, rel_vec, grant_vec, alloc_vec;
  logic [NUM_SM*THR_W-1:0]  thr_flat;
  logic [NUM_SM*SMEM_W-1:0] smem_flat;
  logic [NUM_SM*REG_W-1:0]  reg_flat;

  // launch screening
  assign req_regs = MUL_W'(launch_threads) * MUL_W'(launch_regs);
  assign bad = (launch_blocks == '0) || (launch_threads == '0) ||
               (launch_threads > THR_W'(BLK_THREAD_MAX)) ||
               (launch_smem > SMEM_W'(SM_SMEM_CAP)) ||
               (req_regs > MUL_W'(SM_REG_CAP));
  assign accept = launch_valid && !busy_q && !bad;
  assign rej_d  = launch_valid && !busy_q && bad;

  always_comb begin
    cost_in.thr  = launch_threads;
    cost_in.smem = launch_smem;
    cost_in.regs = req_regs[REG_W-1:0];
  end

  // per-slot resource pools
  for (genvar g = 0; g < NUM_SM; g++) begin : g_pool
    logic [OCC_W-1:0] occ_w;
    bd_sm_pool u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .cost      (cost_q),
      .alloc     (alloc_vec[g]),
      .rel_req   (blk_complete[g]),
      .fits      (fits_vec[g]),
      .rel_ok    (rel_vec[g]),
      .occ       (occ_w),
      .thr_used  (thr_flat[g*THR_W +: THR_W]),
      .smem_used (smem_flat[g*SMEM_W +: SMEM_W]),
      .reg_used  (reg_flat[g*REG_W +: REG_W])
    );
    assign sm_occupancy[g*OCC_W +: OCC_W] = occ_w;
  end

  bd_pick #(.N(NUM_SM)) u_pick (
    .req   (fits_vec),
    .grant (grant_vec),
    .idx   (pick_idx),
    .any   (any_fit)
  );

  assign pending   = busy_q && (next_q != total_q);
  assign disp_go   = pending && any_fit;
  assign alloc_vec = grant_vec & {NUM_SM{disp_go}};
  assign fin_sum   = fin_q + BLK_W'($countones(rel_vec));
  assign dv_d      = disp_go;

  // next state
  always_comb begin
    cost_d  = cost_q;
    total_d = total_q;
    next_d  = next_q;
    fin_d   = fin_sum;
    busy_d  = busy_q;
    done_d  = done_q;
    if (accept) begin
      cost_d  = cost_in;
      total_d = launch_blocks;
      next_d  = '0;
      fin_d   = '0;
      busy_d  = 1'b1;
      done_d  = 1'b0;
    end else begin
      if (disp_go) next_d = next_q + 1'b1;
      if (busy_q && (fin_sum == total_q)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  assign st_en = accept | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cost_q  <= '0;
      total_q <= '0;
      next_q  <= '0;
      fin_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (st_en) begin
      cost_q  <= cost_d;
      total_q <= total_d;
      next_q  <= next_d;
      fin_q   <= fin_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_q <= 1'b0;
      dv_q  <= 1'b0;
    end else begin
      rej_q <= rej_d;
      dv_q  <= dv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q <= '0;
      ds_q <= '0;
    end else if (disp_go) begin
      db_q <= next_q;
      ds_q <= pick_idx;
    end
  end

  assign launch_reject = rej_q;
  assign disp_valid    = dv_q;
  assign disp_block    = db_q;
  assign disp_sm       = ds_q;
  assign done          = done_q;
endmodule

// File: rtl/bd_checker.sv
module bd_checker
  import bd_pkg::*;
#(
  parameter int NUM_SM = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     launch_valid,
  input logic                     launch_reject,
  input logic                     disp_valid,
  input logic                     done,
  input logic [NUM_SM-1:0]        blk_complete,
  input logic [NUM_SM-1:0]        alloc_vec,
  input logic [NUM_SM*OCC_W-1:0]  sm_occupancy,
  input logic [NUM_SM*THR_W-1:0]  thr_flat,
  input logic [NUM_SM*SMEM_W-1:0] smem_flat,
  input logic [NUM_SM*REG_W-1:0]  reg_flat
);
  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    launch_reject |-> $past(launch_valid)); // R1
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec)); // R4
  AST_GRANT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_vec) |=> disp_valid); // R4
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sm_occupancy == '0)); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !disp_valid); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !launch_valid) |=> done); // R8

  for (genvar g = 0; g < NUM_SM; g++) begin : g_chk
    AST_THR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      thr_flat[g*THR_W +: THR_W] <= THR_W'(SM_THREAD_CAP)); // R2
    AST_SMEM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      smem_flat[g*SMEM_W +: SMEM_W] <= SMEM_W'(SM_SMEM_CAP)); // R2
    AST_REG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      reg_flat[g*REG_W +: REG_W] <= REG_W'(SM_REG_CAP)); // R2
    AST_EMPTY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ((sm_occupancy[g*OCC_W +: OCC_W] == '0) && blk_complete[g] && !alloc_vec[g])
      |=> (sm_occupancy[g*OCC_W +: OCC_W] == '0)); // R9
  end
endmodule

bind block_dispatcher bd_checker #(.NUM_SM(NUM_SM)) u_bd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_valid (launch_valid),
  .launch_reject(launch_reject),
  .disp_valid   (disp_valid),
  .done         (done),
  .blk_complete (blk_complete),
  .alloc_vec    (alloc_vec),
  .sm_occupancy (sm_occupancy),
  .thr_flat     (thr_flat),
  .smem_flat    (smem_flat),
  .reg_flat     (reg_flat)
);

// File: tb/tb_block_dispatcher.sv
module tb_block_dispatcher;
  import bd_pkg::*;
  localparam int NUM_SM = 4;
  localparam int BLK_W  = 16;
  localparam int SM_W   = 2;

  typedef struct packed {
    int blocks;
    int thr;
    int smem;
    int rpt;
    int cap;   // 0: launch must be refused
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{5, 1025, 0, 0, 0},
    '{5, 0, 0, 0, 0},
    '{0, 64, 0, 0, 0},
    '{5, 64, 196609, 0, 0},
    '{5, 1024, 0, 65, 0},
    '{0, 256, 0, 0, 8},
    '{0, 256, 65536, 0, 3},
    '{0, 256, 0, 255, 1},
    '{0, 512, 16384, 64, 2},
    '{0, 1024, 0, 0, 2},
    '{0, 64, 196608, 0, 1},
    '{0, 1024, 0, 64, 1}
  };

  logic                    clk, rst_n;
  logic                    launch_valid;
  logic [BLK_W-1:0]        launch_blocks;
  logic [THR_W-1:0]        launch_threads;
  logic [SMEM_W-1:0]       launch_smem;
  logic [RPT_W-1:0]        launch_regs;
  logic                    launch_reject;
  logic [NUM_SM-1:0]       blk_complete;
  logic                    disp_valid;
  logic [BLK_W-1:0]        disp_block;
  logic [SM_W-1:0]         disp_sm;
  logic [NUM_SM*OCC_W-1:0] sm_occupancy;
  logic                    done;

  int total_chk, fail_chk;
  int exp_id, disp_count, fill_cap;

  block_dispatcher #(.NUM_SM(NUM_SM), .BLK_W(BLK_W)) dut (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid),
    .launch_blocks(launch_blocks), .launch_threads(launch_threads),
    .launch_smem(launch_smem), .launch_regs(launch_regs),
    .launch_reject(launch_reject), .blk_complete(blk_complete),
    .disp_valid(disp_valid), .disp_block(disp_block), .disp_sm(disp_sm),
    .sm_occupancy(sm_occupancy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total_chk++;
    if (!ok) begin
      fail_chk++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int occ_of(input int s);
    return int'(sm_occupancy[s*OCC_W +: OCC_W]);
  endfunction

  // dispatch monitor: ID order (R4) and lowest-slot fill (R5)
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      chk(int'(disp_block) == exp_id, "R4 block id order", int'(disp_block), exp_id);
      if (fill_cap > 0 && exp_id < NUM_SM * fill_cap)
        chk(int'(disp_sm) == exp_id / fill_cap, "R5 lowest slot", int'(disp_sm), exp_id / fill_cap);
      exp_id++;
      disp_count++;
    end
  end

  task automatic do_launch(input int blocks, input int thr, input int smem, input int rpt);
    @(negedge clk);
    exp_id = 0;
    disp_count = 0;
    launch_blocks  = BLK_W'(blocks);
    launch_threads = THR_W'(thr);
    launch_smem    = SMEM_W'(smem);
    launch_regs    = RPT_W'(rpt);
    launch_valid   = 1'b1;
    @(negedge clk);
    launch_valid   = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    total_chk++;
    fail_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total_chk - fail_chk, total_chk);
    $finish;
  end

  initial begin
    total_chk = 0; fail_chk = 0; exp_id = 0; disp_count = 0; fill_cap = 0;
    rst_n = 1'b0; launch_valid = 1'b0; launch_blocks = '0; launch_threads = '0;
    launch_smem = '0; launch_regs = '0; blk_complete = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!disp_valid, "R11 disp_valid", int'(disp_valid), 0);
    chk(!done, "R11 done", int'(done), 0);
    chk(!launch_reject, "R11 reject", int'(launch_reject), 0);
    chk(sm_occupancy == '0, "R11 occupancy", int'(sm_occupancy != '0), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int cap, blocks;
      cap = VECS[v].cap;
      blocks = (cap == 0) ? VECS[v].blocks : NUM_SM * cap + 3;
      fill_cap = cap;
      do_launch(blocks, VECS[v].thr, VECS[v].smem, VECS[v].rpt);
      chk(launch_reject == (cap == 0), "R1 reject flag", int'(launch_reject), int'(cap == 0));
      if (cap == 0) begin
        repeat (3) @(negedge clk);
        chk(disp_count == 0, "R1 no dispatch", disp_count, 0);
        continue;
      end
      chk(!done, "R8 done cleared", int'(done), 0);
      repeat (NUM_SM * cap + 8) @(negedge clk);
      for (int s = 0; s < NUM_SM; s++)
        chk(occ_of(s) == cap, "R2/R3 resident limit", occ_of(s), cap);
      chk(disp_count == NUM_SM * cap, "R7 queued wait", disp_count, NUM_SM * cap);
      chk(!done, "R8 not done early", int'(done), 0);
      blk_complete = '1;
      for (int c = 0; c < 400; c++) begin
        @(negedge clk);
        if (done) break;
      end
      blk_complete = '0;
      chk(disp_count == blocks, "R7 all dispatched", disp_count, blocks);
      chk(done, "R8 done raised", int'(done), 1);
      chk(sm_occupancy == '0, "R8 slots empty", int'(sm_occupancy != '0), 0);
    end

    // directed: same-cycle reuse, busy launch, empty strobes
    fill_cap = 1;
    do_launch(5, 256, 0, 255);
    repeat (8) @(negedge clk);
    chk(disp_count == 4, "R7 one per slot", disp_count, 4);
    blk_complete = 4'b0100;
    @(negedge clk);
    blk_complete = '0;
    chk(disp_valid && disp_block == 4, "R6 reuse block", int'(disp_block), 4);
    chk(disp_sm == 2, "R6 reuse slot", int'(disp_sm), 2);
    launch_blocks = 9; launch_threads = 2000; launch_valid = 1'b1;
    @(negedge clk);
    launch_valid = 1'b0;
    chk(!launch_reject, "R10 no reject while busy", int'(launch_reject), 0);
    @(negedge clk);
    chk(disp_count == 5, "R10 no new blocks", disp_count, 5);
    chk(occ_of(2) == 1, "R10 occupancy kept", occ_of(2), 1);
    blk_complete = 4'b0001;
    @(negedge clk);
    blk_complete = 4'b0001;
    @(negedge clk);
    blk_complete = '0;
    chk(occ_of(0) == 0, "R9 empty strobe occupancy", occ_of(0), 0);
    blk_complete = 4'b0110;
    @(negedge clk);
    blk_complete = '0;
    chk(!done, "R9 phantom completion", int'(done), 0);
    blk_complete = 4'b1000;
    @(negedge clk);
    blk_complete = '0;
    chk(done, "R8 done after last", int'(done), 1);
    blk_complete = '1;
    repeat (3) @(negedge clk);
    blk_complete = '0;
    chk(done, "R8 done held", int'(done), 1);
    chk(sm_occupancy == '0, "R9 idle strobes", int'(sm_occupancy != '0), 0);

    $display("%0d/%0d checks passed", total_chk - fail_chk, total_chk);
    $finish;
  end
endmodule